// File: doc/BRIEF.md
# Event Detect and Timestamp Controller

This block watches an active-low external event (tamper) pin for a real-time clock. It runs from the 32.768 kHz timekeeping clock. The pin is synchronized and then passed through a selectable stability filter. It is examined only at selectable sample instants, so a slow rate lets the surrounding logic duty-cycle the input. The first qualified high-to-low transition copies the live calendar word into a timestamp register and sets an event flag. Any further event leaves both untouched until the flag is cleared.

The block holds its own 7-bit configuration word, loaded with a write strobe. That word can arm a halt-on-event option. When armed, the captured event raises a halt output that freezes the external calendar counters. The halt is released by a time-set write from the host, and that same write disarms the option. The event-detect output pin reflects the flag. It can be forced inactive while the chip runs from its backup battery.

Top module: `rtc_evt_det`

## Requirements
- R1: After reset the flag, the timestamp, the halt output, the event-detect output and the configuration readback are all zero.
- R2: The configuration word fields are [6:5] sample rate, [4:3] filter, [2] enable, [1] halt-on-event and [0] battery output disable. With rate 00 the pin is examined every clock, and with filter 00 a low level is taken at once. A low pin then sets the flag and captures `timeNow` within a few clocks.
- R3: Rate 01, 10 and 11 examine the pin every HALF_SEC_CYC, 2×HALF_SEC_CYC and 8×HALF_SEC_CYC clocks. The sampling phase restarts on every configuration write, so no event is seen before the first full period after the write.
- R4: Filter 01, 10 and 11 require the synchronized pin to stay low for FILT_SHORT, FILT_MID and FILT_LONG clocks before it qualifies. Any high clock inside that window restarts the count.
- R5: With enable 0 no event is detected and neither the flag nor the timestamp changes.
- R6: Once the flag is set, the timestamp keeps its value through later events until the flag is cleared.
- R7: A `statusClr` strobe clears the flag and zeroes the timestamp, and a later event is captured again.
- R8: When halt-on-event is 1, the captured event raises `haltCount`. When it is 0, `haltCount` stays low.
- R9: An `rtcWrite` strobe drops `haltCount` and clears the halt-on-event bit in the configuration readback.
- R10: With enable 0, halt-on-event has no effect and `haltCount` stays low.
- R11: `evDetOut` equals the flag, except that it is 0 when the battery output disable bit is 1 and `onBattery` is 1.
- R12: An event is a transition to low. A pin held low after a clear does not set the flag again until it has been seen high at a sample instant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evPinN | input | 1 | Raw active-low event pin |
| cfgWe | input | 1 | Configuration load strobe |
| cfgIn | input | 7 | Configuration word to load |
| timeNow | input | TIME_W | Live calendar word |
| rtcWrite | input | 1 | Time-set write strobe |
| statusClr | input | 1 | Event flag clear strobe |
| onBattery | input | 1 | Backup battery mode flag |
| eventFlag | output | 1 | Event status flag |
| stampOut | output | TIME_W | Latched timestamp |
| haltCount | output | 1 | Freeze calendar counting |
| evDetOut | output | 1 | Event-detect output pin |
| cfgOut | output | 7 | Configuration readback |

## Verification
The bench aims at the sample-phase boundary after a configuration write. A design with the wrong period, or with no phase restart, flags the event too early or too late. The bench also sends a low pulse shorter than the filter, and a low run broken by a brief high. A filter that does not restart, or that maps the field codes wrongly, would accept these as events. It holds the pin low across a status clear, which a level-sensitive detector would take as a second event. It sends a second event after the first, which a design that re-captures would use to overwrite the timestamp. It also checks that the time-set write both releases the halt and disarms the option, and that halt-on-event is inert while detection is disabled.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  typedef struct packed {
    logic [1:0] rate;
    logic [1:0] filt;
    logic       enable;
    logic       haltOn;
    logic       batOff;
  } evtCfg_t;

  typedef struct packed {
    logic detect;
    logic clrFlag;
    logic rtcWr;
  } evtStb_t;
endpackage

// File: rtl/rtc_evt_ctrl.sv
module rtc_evt_ctrl
  import rtc_evt_pkg::*;
#(
  parameter int HALF_SEC_CYC = 16384,
  parameter int FILT_SHORT   = 128,
  parameter int FILT_MID     = 512,
  parameter int FILT_LONG    = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       evPinN,
  input  logic       cfgWe,
  input  logic [1:0] rateSel,
  input  logic [1:0] filtSel,
  input  logic       enable,
  input  logic       statusClr,
  input  logic       rtcWrite,
  output evtStb_t    stb
);
  localparam int PER_W = $clog2(8 * HALF_SEC_CYC + 1);
  localparam int FLT_W = $clog2(FILT_LONG + 1);

  logic [1:0]       syncQ;
  logic             pinLow;
  logic [FLT_W-1:0] lowCnt;
  logic [FLT_W-1:0] filtTarget;
  logic             qualified;
  logic [PER_W-1:0] perCnt;
  logic [PER_W-1:0] periodM1;
  logic             tick;
  logic             lastHigh;

  // two-stage synchronizer, rests high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], evPinN};
  end
  assign pinLow = !syncQ[1];

  // stability filter: count consecutive low clocks, restart on any high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              lowCnt <= '0;
    else if (!pinLow)                       lowCnt <= '0;
    else if (lowCnt != FLT_W'(FILT_LONG))   lowCnt <= lowCnt + 1'b1;
  end

  always_comb begin
    case (filtSel)
      2'd0:    filtTarget = '0;
      2'd1:    filtTarget = FLT_W'(FILT_SHORT);
      2'd2:    filtTarget = FLT_W'(FILT_MID);
      default: filtTarget = FLT_W'(FILT_LONG);
    endcase
  end
  assign qualified = pinLow && (lowCnt >= filtTarget);

  // sample instant generator, phase restarts on configuration write
  always_comb begin
    case (rateSel)
      2'd0:    periodM1 = '0;
      2'd1:    periodM1 = PER_W'(HALF_SEC_CYC - 1);
      2'd2:    periodM1 = PER_W'(2 * HALF_SEC_CYC - 1);
      default: periodM1 = PER_W'(8 * HALF_SEC_CYC - 1);
    endcase
  end
  assign tick = (perCnt >= periodM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      perCnt <= '0;
    else if (cfgWe) perCnt <= '0;
    else if (tick)  perCnt <= '0;
    else            perCnt <= perCnt + 1'b1;
  end

  // level seen at the previous sample instant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lastHigh <= 1'b1;
    else if (!enable) lastHigh <= 1'b1;
    else if (tick)    lastHigh <= !qualified;
  end

  assign stb.detect  = enable && tick && qualified && lastHigh;
  assign stb.clrFlag = statusClr;
  assign stb.rtcWr   = rtcWrite;

  AST_ONE_DETECT_PER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.detect |=> !stb.detect); // R12
endmodule

// File: rtl/rtc_evt_dp.sv
module rtc_evt_dp
  import rtc_evt_pkg::*;
#(
  parameter int TIME_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  evtCfg_t           cfgIn,
  input  logic [TIME_W-1:0] timeNow,
  input  logic              onBattery,
  input  evtStb_t           stb,
  output evtCfg_t           cfgQ,
  output logic              flagQ,
  output logic [TIME_W-1:0] stampQ,
  output logic              haltQ,
  output logic              evOut
);
  logic capture;
  assign capture = stb.detect && !flagQ;

  // configuration word; a time-set write disarms halt-on-event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else begin
      if (cfgWe)     cfgQ <= cfgIn;
      if (stb.rtcWr) cfgQ.haltOn <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      stampQ <= '0;
    end else if (stb.clrFlag) begin
      flagQ  <= 1'b0;
      stampQ <= '0;
    end else if (capture) begin
      flagQ  <= 1'b1;
      stampQ <= timeNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         haltQ <= 1'b0;
    else if (stb.rtcWr)                haltQ <= 1'b0;
    else if (capture && cfgQ.haltOn)   haltQ <= 1'b1;
  end

  assign evOut = flagQ && !(cfgQ.batOff && onBattery);

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(cfgQ.enable)); // R5
  AST_HALT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltQ) |-> $past(cfgQ.enable)); // R10
  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && $past(flagQ)) |-> $stable(stampQ)); // R6
  AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrFlag |=> (!flagQ && stampQ == '0)); // R7
  AST_HALT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stb.rtcWr |=> (!haltQ && !cfgQ.haltOn)); // R9
endmodule

// File: rtl/rtc_evt_det.sv
module rtc_evt_det
  import rtc_evt_pkg::*;
#(
  parameter int TIME_W       = 48,
  parameter int HALF_SEC_CYC = 16384,
  parameter int FILT_SHORT   = 128,
  parameter int FILT_MID     = 512,
  parameter int FILT_LONG    = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evPinN,
  input  logic              cfgWe,
  input  logic [6:0]        cfgIn,
  input  logic [TIME_W-1:0] timeNow,
  input  logic              rtcWrite,
  input  logic              statusClr,
  input  logic              onBattery,
  output logic              eventFlag,
  output logic [TIME_W-1:0] stampOut,
  output logic              haltCount,
  output logic              evDetOut,
  output logic [6:0]        cfgOut
);
  evtStb_t stb;
  evtCfg_t cfgQ;

  rtc_evt_ctrl #(
    .HALF_SEC_CYC(HALF_SEC_CYC),
    .FILT_SHORT  (FILT_SHORT),
    .FILT_MID    (FILT_MID),
    .FILT_LONG   (FILT_LONG)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evPinN   (evPinN),
    .cfgWe    (cfgWe),
    .rateSel  (cfgQ.rate),
    .filtSel  (cfgQ.filt),
    .enable   (cfgQ.enable),
    .statusClr(statusClr),
    .rtcWrite (rtcWrite),
    .stb      (stb)
  );

  rtc_evt_dp #(.TIME_W(TIME_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgIn    (evtCfg_t'(cfgIn)),
    .timeNow  (timeNow),
    .onBattery(onBattery),
    .stb      (stb),
    .cfgQ     (cfgQ),
    .flagQ    (eventFlag),
    .stampQ   (stampOut),
    .haltQ    (haltCount),
    .evOut    (evDetOut)
  );

  assign cfgOut = cfgQ;
endmodule

// File: tb/rtc_evt_det_tb.sv
module rtc_evt_det_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evPinN = 1'b1;
  logic        cfgWe = 1'b0;
  logic [6:0]  cfgIn = '0;
  logic [31:0] timeNow = '0;
  logic        rtcWrite = 1'b0;
  logic        statusClr = 1'b0;
  logic        onBattery = 1'b0;
  logic        eventFlag, haltCount, evDetOut;
  logic [31:0] stampOut;
  logic [6:0]  cfgOut;
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_evt_det #(
    .TIME_W(32), .HALF_SEC_CYC(40), .FILT_SHORT(8), .FILT_MID(16), .FILT_LONG(32)
  ) u_dut (
    .clk(clk), .rstN(rstN), .evPinN(evPinN), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .timeNow(timeNow), .rtcWrite(rtcWrite), .statusClr(statusClr),
    .onBattery(onBattery), .eventFlag(eventFlag), .stampOut(stampOut),
    .haltCount(haltCount), .evDetOut(evDetOut), .cfgOut(cfgOut)
  );

  // {batOff, onBattery, expected evDetOut} with the flag set
  localparam logic [2:0] R11_VEC [4] = '{3'b001, 3'b011, 3'b101, 3'b110};

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writeCfg(logic [6:0] v);
    @(posedge clk); #1 cfgWe = 1'b1; cfgIn = v;
    @(posedge clk); #1 cfgWe = 1'b0;
  endtask

  task automatic pulseClr();
    @(posedge clk); #1 statusClr = 1'b1;
    @(posedge clk); #1 statusClr = 1'b0;
  endtask

  task automatic rearm();
    evPinN = 1'b1;
    writeCfg(7'h00);
    pulseClr();
    cyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    cyc(3);
    chk("R1 flag", eventFlag, 0);
    chk("R1 stamp", stampOut, 0);
    chk("R1 halt", haltCount, 0);
    chk("R1 evDetOut", evDetOut, 0);
    chk("R1 cfgOut", cfgOut, 0);
    rstN = 1'b1;
    cyc(2);

    // R5 / R10: disabled, halt-on-event armed
    writeCfg(7'h02);
    timeNow = 32'h99;
    evPinN = 1'b0; cyc(20);
    chk("R5 flag disabled", eventFlag, 0);
    chk("R5 stamp disabled", stampOut, 0);
    chk("R10 halt disabled", haltCount, 0);
    rearm();

    // R2 continuous, no filter
    writeCfg(7'h04);
    timeNow = 32'hA1;
    evPinN = 1'b0; cyc(6);
    chk("R2 flag", eventFlag, 1);
    chk("R2 stamp", stampOut, 32'hA1);
    chk("R8 halt off", haltCount, 0);

    // R12 pin held low across clear
    pulseClr(); cyc(20);
    chk("R12 no re-detect", eventFlag, 0);
    chk("R7 stamp zeroed", stampOut, 0);

    // R6 first event held
    evPinN = 1'b1; cyc(6);
    timeNow = 32'hB2; evPinN = 1'b0; cyc(6);
    chk("R6 first stamp", stampOut, 32'hB2);
    evPinN = 1'b1; cyc(6);
    timeNow = 32'hC3; evPinN = 1'b0; cyc(10);
    chk("R6 stamp held", stampOut, 32'hB2);
    chk("R6 flag held", eventFlag, 1);
    evPinN = 1'b1;

    // R11 output gating, vector walk
    foreach (R11_VEC[i]) begin
      writeCfg({5'b00001, 1'b0, R11_VEC[i][2]});
      onBattery = R11_VEC[i][1];
      cyc(2);
      chk("R11 evDetOut", evDetOut, 32'(R11_VEC[i][0]));
    end
    onBattery = 1'b0;

    // R7 clear and re-capture
    pulseClr(); cyc(2);
    chk("R7 flag cleared", eventFlag, 0);
    chk("R7 evDetOut cleared", evDetOut, 0);
    cyc(4);
    timeNow = 32'hD4; evPinN = 1'b0; cyc(6);
    chk("R7 recapture", stampOut, 32'hD4);
    rearm();

    // R4 filter 01 (8 clocks)
    writeCfg(7'h0C);
    evPinN = 1'b0; cyc(4); evPinN = 1'b1; cyc(20);
    chk("R4 short pulse rejected", eventFlag, 0);
    evPinN = 1'b0; cyc(30);
    chk("R4 long low accepted", eventFlag, 1);
    rearm();

    // R4 filter 11 (32 clocks) with restart
    writeCfg(7'h1C);
    evPinN = 1'b0; cyc(20);
    chk("R4 below long filter", eventFlag, 0);
    evPinN = 1'b1; cyc(3); evPinN = 1'b0; cyc(20);
    chk("R4 restart after glitch", eventFlag, 0);
    cyc(25);
    chk("R4 long filter met", eventFlag, 1);
    rearm();

    // R3 sample rates: 40, 80, 320 clocks after the write
    writeCfg(7'h24); evPinN = 1'b0; cyc(25);
    chk("R3 rate01 before tick", eventFlag, 0);
    cyc(25);
    chk("R3 rate01 after tick", eventFlag, 1);
    rearm();
    writeCfg(7'h44); evPinN = 1'b0; cyc(70);
    chk("R3 rate10 before tick", eventFlag, 0);
    cyc(20);
    chk("R3 rate10 after tick", eventFlag, 1);
    rearm();
    writeCfg(7'h64); evPinN = 1'b0; cyc(300);
    chk("R3 rate11 before tick", eventFlag, 0);
    cyc(40);
    chk("R3 rate11 after tick", eventFlag, 1);
    rearm();

    // R8 / R9 halt and release
    writeCfg(7'h06);
    timeNow = 32'hE5; evPinN = 1'b0; cyc(6);
    chk("R8 halt raised", haltCount, 1);
    chk("R8 haltOn still set", cfgOut[1], 1);
    @(posedge clk); #1 rtcWrite = 1'b1;
    @(posedge clk); #1 rtcWrite = 1'b0;
    cyc(1);
    chk("R9 halt released", haltCount, 0);
    chk("R9 haltOn cleared", cfgOut[1], 0);
    chk("R9 enable kept", cfgOut[2], 1);
    evPinN = 1'b1; pulseClr(); cyc(6);
    evPinN = 1'b0; cyc(6);
    chk("R9 no halt after disarm", haltCount, 0);
    chk("R9 event still captured", eventFlag, 1);

    finishRun();
  end
endmodule